// File: doc/BRIEF.md
# SPI Master Burst Shift Engine

This block is the shifting core of an SPI master. It clocks one burst of whole 8-bit bytes per start command. Transmit bytes come from an external transmit FIFO through a valid/ready stream. Received bytes go out to an external receive FIFO through a second valid/ready stream. Bit timing comes from `sclk_tick`, a one-cycle enable pulse made by a divider outside the block. Each tick moves SCLK by one half period. The divider, the FIFO storage and the register file are outside the block. The register file writes the control word through `ctrl_wr`/`ctrl_wdata` and reads it back on `ctrl_rdata`.

A burst has two lengths, both latched at start. `burst_len` is the number of bytes clocked on the wire. `tx_len` is the number of those bytes taken from the transmit stream. Bytes after the transmit count are padded with 0x00. Four chip-select lines are handled by the engine: automatically around the burst, or held at a level that software sets.

Flow-control rules. The engine asserts `tx_ready` only when it needs the next transmit byte, and no SCLK edge occurs while that byte is missing. A received byte stays on `rx_data` with `rx_valid` high until `rx_ready` is seen. The next byte does not begin until that handoff has happened.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `ctrl_rdata` is 0, `sclk` is 0, all `cs` lines are 0, and `tx_ready`, `rx_valid` and `xfer_done` are low.
- R2: A control write with bit 31 set, made while bit 31 reads 0, starts a burst. Bit 31 then reads 1 until the burst ends. At the end it clears in the same cycle as a one-cycle `xfer_done` pulse. Control writes made while bit 31 reads 1 are ignored.
- R3: Each byte takes 16 ticks (8 SCLK periods). SCLK rests at control bit 1 (polarity) and changes only on a tick. With control bit 0 clear, a bit is presented before its leading edge and sampled on the leading edge. With bit 0 set, a bit is presented on the leading edge and sampled on the trailing edge.
- R4: Control bit 12 set sends and receives each byte LSB first. Clear means MSB first.
- R5: The first min(`tx_len`, `burst_len`) bytes are taken from the transmit stream. Every later byte of the burst is sent as 0x00 with no transmit handshake.
- R6: While a transmit byte is needed and `tx_valid` is low, SCLK stays at its rest level. The burst resumes when data arrives.
- R7: Each received byte is offered with `rx_valid` high and `rx_data` held stable until `rx_ready`. SCLK stays at rest until the byte is accepted.
- R8: With control bit 8 set, no received byte is offered (`rx_valid` stays low).
- R9: Control bits [5:4] select one of four lines, and control bit 2 gives the idle level (1 = idle high, active low). Without manual mode, the selected line is active from start to completion, and every other line stays idle.
- R10: With control bit 6 set, the selected line follows control bit 7 whether or not a burst runs. The other lines stay at the idle level.
- R11: A burst with `burst_len` of 0 completes at once. It produces no SCLK edge and no transmit handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word to write |
| ctrl_rdata | output | 32 | Current control word, bit 31 = start/busy |
| burst_len | input | CNT_W | Total bytes in the burst, latched at start |
| tx_len | input | CNT_W | Bytes taken from the transmit stream, latched at start |
| sclk_tick | input | 1 | Half-period pacing enable from the divider |
| tx_valid | input | 1 | Transmit byte available |
| tx_ready | output | 1 | Engine takes a transmit byte |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte offered |
| rx_ready | input | 1 | Receive side accepts the byte |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | NUM_CS | Chip-select lines |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The bench runs every combination of the four clock modes and both bit orders. Each combination is tried with several pairs of burst and transmit lengths: zero, equal, transmit shorter, transmit zero and transmit longer. Some of these pairs also set the discard bit. A slave model with its own distinct byte pattern tells apart phase and bit-order mistakes. The pad-byte cases separate FIFO-sourced bytes from 0x00 padding, and the longer-transmit case shows that surplus data is left unpopped. A gated `tx_valid` window and a slow `rx_ready` create stalls and back-pressure mid-burst. A mid-burst control write with every mode bit inverted shows that the configuration stays locked while a burst runs.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int BYTE_W     = 8;
  localparam int CB_CPHA    = 0;
  localparam int CB_CPOL    = 1;
  localparam int CB_SPOL    = 2;
  localparam int CB_CSIDX   = 4;
  localparam int CB_MANUAL  = 6;
  localparam int CB_LEVEL   = 7;
  localparam int CB_DISCARD = 8;
  localparam int CB_LSB     = 12;
  localparam int CB_START   = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_PUSH} eng_state_e;

  // position in the byte of the k-th bit on the wire
  function automatic logic [2:0] wire_pos(input logic [2:0] k, input logic lsb_first);
    return lsb_first ? k : (3'd7 - k);
  endfunction
endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_word,
  input  logic        clr_start,
  output logic [31:0] word_q,
  output logic        start
);
  logic busy;
  assign busy  = word_q[CB_START];
  assign start = wr_en && !busy && wr_word[CB_START];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (wr_en && !busy) begin
      word_q <= wr_word;
    end else if (clr_start) begin
      word_q[CB_START] <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_eng_csel.sv
module spi_eng_csel #(
  parameter int NUM_CS   = 4,
  parameter int CS_IDX_W = 2
) (
  input  logic [CS_IDX_W-1:0] sel,
  input  logic                idle_lvl,
  input  logic                manual,
  input  logic                man_lvl,
  input  logic                busy,
  output logic [NUM_CS-1:0]   cs
);
  logic sel_lvl;
  assign sel_lvl = manual ? man_lvl : (busy ? ~idle_lvl : idle_lvl);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs[i] = (sel == CS_IDX_W'(i)) ? sel_lvl : idle_lvl;
  end
endmodule

// File: rtl/spi_eng_shift.sv
module spi_eng_shift
  import spi_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              last
);
  logic [3:0]        half;
  logic              phase;
  logic [BYTE_W-1:0] tx_byte;
  logic              mosi_q;
  logic [2:0]        k;
  logic              leading;

  assign k       = half[3:1];
  assign leading = ~half[0];
  assign sclk    = active ? (cpol ^ phase) : cpol;
  assign mosi    = mosi_q;
  assign last    = active && tick && (half == 4'd15);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half    <= '0;
      phase   <= 1'b0;
      tx_byte <= '0;
      rx_byte <= '0;
      mosi_q  <= 1'b0;
    end else if (load) begin
      half    <= '0;
      phase   <= 1'b0;
      tx_byte <= load_byte;
      if (!cpha) mosi_q <= load_byte[wire_pos(3'd0, lsb_first)];
    end else if (active && tick) begin
      phase <= ~phase;
      half  <= half + 4'd1;
      if (leading) begin
        if (cpha) mosi_q <= tx_byte[wire_pos(k, lsb_first)];
        else      rx_byte[wire_pos(k, lsb_first)] <= miso;
      end else begin
        if (cpha)           rx_byte[wire_pos(k, lsb_first)] <= miso;
        else if (k != 3'd7) mosi_q <= tx_byte[wire_pos(k + 3'd1, lsb_first)];
      end
    end
  end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [31:0]       ctrl_wdata,
  output logic [31:0]       ctrl_rdata,
  input  logic [CNT_W-1:0]  burst_len,
  input  logic [CNT_W-1:0]  tx_len,
  input  logic              sclk_tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs,
  output logic              xfer_done
);
  localparam int CS_IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  eng_state_e        state;
  logic [CNT_W-1:0]  burst_rem;
  logic [CNT_W-1:0]  tx_rem;
  logic              start;
  logic              finish;
  logic              load;
  logic              last;
  logic              done_q;
  logic [BYTE_W-1:0] load_byte;
  logic [31:0]       cw;

  assign ctrl_rdata = cw;
  assign xfer_done  = done_q;
  assign finish     = (state == ST_LOAD) && (burst_rem == '0);
  assign tx_ready   = (state == ST_LOAD) && (burst_rem != '0) && (tx_rem != '0);
  assign load       = (state == ST_LOAD) && (burst_rem != '0) && ((tx_rem == '0) || tx_valid);
  assign load_byte  = (tx_rem == '0) ? '0 : tx_data;
  assign rx_valid   = (state == ST_PUSH);

  spi_eng_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctrl_wr),
    .wr_word   (ctrl_wdata),
    .clr_start (finish),
    .word_q    (cw),
    .start     (start)
  );

  spi_eng_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (state == ST_SHIFT),
    .load      (load),
    .load_byte (load_byte),
    .tick      (sclk_tick),
    .cpol      (cw[CB_CPOL]),
    .cpha      (cw[CB_CPHA]),
    .lsb_first (cw[CB_LSB]),
    .miso      (miso),
    .sclk      (sclk),
    .mosi      (mosi),
    .rx_byte   (rx_data),
    .last      (last)
  );

  spi_eng_csel #(.NUM_CS(NUM_CS), .CS_IDX_W(CS_IDX_W)) u_csel (
    .sel      (cw[CB_CSIDX +: CS_IDX_W]),
    .idle_lvl (cw[CB_SPOL]),
    .manual   (cw[CB_MANUAL]),
    .man_lvl  (cw[CB_LEVEL]),
    .busy     (cw[CB_START]),
    .cs       (cs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      burst_rem <= '0;
      tx_rem    <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          burst_rem <= burst_len;
          tx_rem    <= tx_len;
          state     <= ST_LOAD;
        end
        ST_LOAD: if (finish) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end else if (load) begin
          if (tx_rem != '0) tx_rem <= tx_rem - CNT_W'(1);
          state <= ST_SHIFT;
        end
        ST_SHIFT: if (last) begin
          burst_rem <= burst_rem - CNT_W'(1);
          state     <= cw[CB_DISCARD] ? ST_LOAD : ST_PUSH;
        end
        ST_PUSH: if (rx_ready) state <= ST_LOAD;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk #(
  parameter int NUM_CS   = 4,
  parameter int CS_IDX_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                cpol,
  input logic                spol,
  input logic [CS_IDX_W-1:0] sel,
  input logic                manual,
  input logic                man_lvl,
  input logic                discard,
  input logic                sclk_tick,
  input logic                sclk,
  input logic                tx_ready,
  input logic                rx_valid,
  input logic                rx_ready,
  input logic [7:0]          rx_data,
  input logic [NUM_CS-1:0]   cs,
  input logic                xfer_done
);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !busy);
  p_sclk_rest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cpol);
  p_sclk_paced_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sclk_tick |=> $stable(sclk));
  p_tx_only_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> busy);
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
  p_rx_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> sclk == cpol);
  p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && discard |-> !rx_valid);
  p_cs_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !manual |-> cs == {NUM_CS{spol}});
  p_cs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs ^ {NUM_CS{spol}}) <= 1);
  p_cs_manual_r10: assert property (@(posedge clk) disable iff (!rst_n)
    manual |-> cs[sel] == man_lvl);
endmodule

bind spi_xfer_engine spi_xfer_engine_chk #(.NUM_CS(NUM_CS), .CS_IDX_W(CS_IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (ctrl_rdata[31]),
  .cpol      (ctrl_rdata[1]),
  .spol      (ctrl_rdata[2]),
  .sel       (ctrl_rdata[4 +: CS_IDX_W]),
  .manual    (ctrl_rdata[6]),
  .man_lvl   (ctrl_rdata[7]),
  .discard   (ctrl_rdata[8]),
  .sclk_tick (sclk_tick),
  .sclk      (sclk),
  .tx_ready  (tx_ready),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .cs        (cs),
  .xfer_done (xfer_done)
);

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;
  localparam int CNT_W  = 24;
  localparam int NUM_CS = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctrl_wr = 1'b0;
  logic [31:0]       ctrl_wdata = '0;
  logic [31:0]       ctrl_rdata;
  logic [CNT_W-1:0]  burst_len = '0;
  logic [CNT_W-1:0]  tx_len = '0;
  logic              sclk_tick = 1'b0;
  logic              tx_valid = 1'b0;
  logic              tx_ready;
  logic [7:0]        tx_data = '0;
  logic              rx_valid;
  logic              rx_ready = 1'b0;
  logic [7:0]        rx_data;
  logic              sclk;
  logic              mosi;
  logic              miso = 1'b0;
  logic [NUM_CS-1:0] cs;
  logic              xfer_done;

  always #5 clk = ~clk;

  spi_xfer_engine #(.CNT_W(CNT_W), .NUM_CS(NUM_CS)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .burst_len(burst_len), .tx_len(tx_len),
    .sclk_tick(sclk_tick), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs(cs),
    .xfer_done(xfer_done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // run configuration
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_lsb = 0, cfg_disc = 0;
  logic cfg_man = 0, cfg_lvl = 0, cfg_spol = 0;
  logic [1:0] cfg_idx = 0;
  int run_burst = 0, run_txn = 0;
  logic [7:0] tx_mem [8];
  logic [7:0] sl_mem [8];

  // monitor state
  int cyc = 0, tx_ptr = 0, pops = 0, rx_idx = 0, edges = 0;
  int sb_idx = 0, sb_bit = 0, mbytes = 0;
  logic [7:0] mosi_acc = '0;
  logic sclk_prev = 0, busy_prev = 0, tx_pop_q = 0, rx_pop_q = 0;

  function automatic int bpos(input int k);
    return cfg_lsb ? k : 7 - k;
  endfunction

  function automatic logic [3:0] exp_cs(input logic busy);
    logic [3:0] r;
    r = {4{cfg_spol}};
    r[cfg_idx] = cfg_man ? cfg_lvl : (busy ? ~cfg_spol : cfg_spol);
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) begin tx_mem[i] = '0; sl_mem[i] = '0; end
    forever begin
      @(negedge clk);
      cyc++;
      if (tx_pop_q) begin tx_ptr++; pops++; end
      if (rx_pop_q) begin
        if (cfg_disc) chk(0, "R8", "byte offered in discard mode", 1, 0);
        else chk(rx_data == sl_mem[rx_idx % 8], cfg_lsb ? "R4" : "R7",
                 "received byte", rx_data, sl_mem[rx_idx % 8]);
        rx_idx++;
      end
      if (ctrl_rdata[31] && busy_prev && sclk !== sclk_prev) begin
        edges++;
        if ((sclk != cfg_cpol) ^ cfg_cpha) begin
          mosi_acc[bpos(sb_bit)] = mosi;
          chk(cs == exp_cs(1'b1), cfg_man ? "R10" : "R9", "cs during burst", cs, exp_cs(1'b1));
          sb_bit++;
          if (sb_bit == 8) begin
            logic [7:0] e;
            e = (sb_idx < run_txn) ? tx_mem[sb_idx % 8] : 8'h00;
            chk(mosi_acc == e, (sb_idx >= run_txn) ? "R5" : (cfg_lsb ? "R4" : "R3"),
                "sent byte", mosi_acc, e);
            sb_bit = 0; sb_idx++; mbytes++;
          end
        end
      end
      sclk_prev = sclk;
      busy_prev = ctrl_rdata[31];
      if (tx_ready && !tx_valid) chk(sclk == cfg_cpol, "R6", "sclk while starved", sclk, cfg_cpol);
      if (rx_valid && !rx_ready) chk(sclk == cfg_cpol, "R7", "sclk while rx held", sclk, cfg_cpol);
      sclk_tick = (cyc % 3) == 0;
      tx_valid  = (tx_ptr < 8) && ((cyc % 97) < 60);
      tx_data   = (tx_ptr < 8) ? tx_mem[tx_ptr] : 8'h00;
      rx_ready  = (cyc % 13) > 4;
      miso      = (sb_idx < 8) ? sl_mem[sb_idx][bpos(sb_bit)] : 1'b0;
      tx_pop_q  = tx_valid && tx_ready;
      rx_pop_q  = rx_valid && rx_ready;
    end
  end

  task automatic wr_ctrl(input logic [31:0] w);
    @(negedge clk);
    ctrl_wdata = w;
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic run(input int mode, input logic lsb, input int bl, input int tl,
                     input logic disc, input logic [1:0] idx, input logic spol,
                     input logic man, input logic lvl);
    logic [31:0] w;
    int wait_n;
    @(negedge clk);
    cfg_cpha = mode[0]; cfg_cpol = mode[1]; cfg_lsb = lsb; cfg_disc = disc;
    cfg_idx = idx; cfg_spol = spol; cfg_man = man; cfg_lvl = lvl;
    run_burst = bl; run_txn = (tl < bl) ? tl : bl;
    for (int i = 0; i < 8; i++) begin
      tx_mem[i] = 8'h5A ^ 8'((i * 37 + mode * 11 + bl) & 255);
      sl_mem[i] = 8'hC3 + 8'((i * 29 + tl * 7 + int'(lsb) * 5) & 255);
    end
    tx_ptr = 0; pops = 0; rx_idx = 0; edges = 0; sb_idx = 0; sb_bit = 0; mbytes = 0;
    burst_len = CNT_W'(bl); tx_len = CNT_W'(tl);
    w = '0;
    w[0] = mode[0]; w[1] = mode[1]; w[2] = spol; w[5:4] = idx;
    w[6] = man; w[7] = lvl; w[8] = disc; w[12] = lsb; w[31] = 1'b1;
    ctrl_wdata = w;
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk(ctrl_rdata == w, "R2", "control after start", ctrl_rdata, w);
    if (bl >= 2) begin
      repeat (20) @(negedge clk);
      wr_ctrl(~w & 32'h7fff_ffff);
      chk(ctrl_rdata == w, "R2", "write while busy ignored", ctrl_rdata, w);
    end
    wait_n = 0;
    while (!xfer_done && wait_n < 30000) begin @(negedge clk); wait_n++; end
    chk(xfer_done == 1'b1, "R2", "completion pulse seen", xfer_done, 1);
    @(negedge clk);
    chk(xfer_done == 1'b0, "R2", "completion pulse one cycle", xfer_done, 0);
    chk(ctrl_rdata[31] == 1'b0, "R2", "start bit self-cleared", ctrl_rdata[31], 0);
    chk(cs == exp_cs(1'b0), man ? "R10" : "R9", "cs after burst", cs, exp_cs(1'b0));
    chk(pops == run_txn, (bl == 0) ? "R11" : "R5", "transmit pops", pops, run_txn);
    chk(edges == 16 * bl, (bl == 0) ? "R11" : "R3", "sclk edge count", edges, 16 * bl);
    chk(mbytes == bl, "R3", "bytes on wire", mbytes, bl);
    chk(rx_idx == (disc ? 0 : bl), disc ? "R8" : "R7", "received count", rx_idx, disc ? 0 : bl);
    chk(sclk == mode[1], "R3", "sclk rest level", sclk, mode[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bls [6] = '{0, 1, 3, 2, 3, 4};
    int tls [6] = '{0, 1, 1, 0, 5, 4};
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ctrl_rdata == 32'h0, "R1", "ctrl after reset", ctrl_rdata, 0);
    chk(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
    chk(cs == 4'h0, "R1", "cs after reset", cs, 0);
    chk({tx_ready, rx_valid, xfer_done} == 3'b000, "R1", "handshakes after reset",
        {tx_ready, rx_valid, xfer_done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 manual level while idle
    wr_ctrl(32'h0000_00E0);
    chk(cs == 4'b0100, "R10", "manual high on line 2", cs, 4'b0100);
    wr_ctrl(32'h0000_0054);
    chk(cs == 4'b1101, "R10", "manual low on line 1, idle high", cs, 4'b1101);
    // R9 auto mode idle high
    wr_ctrl(32'h0000_0034);
    chk(cs == 4'b1111, "R9", "auto idle high", cs, 4'b1111);
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 2; l++)
        for (int c = 0; c < 6; c++)
          run(m, l[0], bls[c], tls[c], (c == 2) || (c == 5 && m[0]),
              2'((m + c) % 4), l[0] ^ m[0], 1'b0, 1'b0);
    run(1, 1'b0, 2, 2, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1);
    run(2, 1'b1, 2, 1, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule